// File: doc/BRIEF.md
# Busy-Synchronized Serial Result Receiver

This block receives fixed-width conversion results from a sampling converter that acts as the serial clock source. The converter drives the serial clock (idle low) and the data line. Its busy output is wired to the select input: the line is low while a conversion runs and goes high when a conversion ends. Data bits are taken on the falling edge of the serial clock, most significant bit first. All three external lines are brought into the system clock domain through a synchronizer chain, and edges are found there.

After reset the receiver does not frame any words. It waits for the first low-to-high transition of the select line, which marks the end of a conversion, and only then sets its synchronized flag and starts counting bits. A word can therefore never start in the middle of a transfer. Any transition of the select line clears a partly received word. Bits that arrive while the select line is low are ignored.

Completed words leave through a valid/ready output. A word is presented with `res_valid` high and stays unchanged until the consumer raises `res_ready`. There is no buffering behind the output register. If a further word completes while `res_valid` is high, including in the cycle it is accepted, that new word is dropped and the word on display is kept. The consumer must therefore accept each result before the next conversion's last bit arrives.

Top module: `busy_sync_serial_rx`

## Requirements
- R1: After reset, `res_valid` is 0 and `synced` is 0. The select synchronizer resets to the high level, so a select line that is already high at reset produces no rising transition.
- R2: Before the first select rising transition, falling serial clock edges produce no word (`res_valid` stays 0).
- R3: `synced` goes to 1 after the first low-to-high transition of the select line and stays 1 until reset. A high-to-low transition alone does not set it.
- R4: With `synced` = 1 and select high, 16 falling serial clock edges assemble one word, first bit in bit 15 (MSB first), presented on `res_data`.
- R5: `res_valid` rises after the 16th falling edge. While `res_valid` = 1 and `res_ready` = 0, `res_valid` and `res_data` hold. `res_valid` returns to 0 in the cycle after a handshake.
- R6: Any select transition while a word is partly received discards the partial bits, and the next word framed is complete and correct.
- R7: Falling serial clock edges while select is low are not counted and do not build a word.
- R8: A word that completes while `res_valid` = 1 is dropped, and the held word is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | External serial clock, idle low |
| ser_data | input | 1 | External serial data, sampled on falling ser_clk |
| ser_sel | input | 1 | Select line driven by converter busy (high = result ready) |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 16 | Received result word |
| synced | output | 1 | Set once framing is aligned, cleared only by reset |

## Verification
The bench builds the block with its defaults: 16-bit words and a two-stage synchronizer. It holds every serial level for four system clocks, so each edge is seen cleanly after the chain. This brings within reach the bit-15 placement of the first bit, the exact 16th-edge boundary, and the latency of a few cycles through the synchronizer and edge detector. Directed cases cover select toggles mid-word, clocking while select is low, clocking before alignment, and a second word arriving against a stalled consumer.

// File: rtl/busy_sync_rx_pkg.sv
package busy_sync_rx_pkg;
  // bit positions of the external lines inside the synchronized bus
  localparam int unsigned LINE_CLK  = 0;
  localparam int unsigned LINE_DATA = 1;
  localparam int unsigned LINE_SEL  = 2;
  localparam int unsigned LINES     = 3;
  // reset levels: clock idle low, data low, select high (no false rise)
  localparam logic [LINES-1:0] LINE_RST = 3'b100;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rx_edge_detect.sv
module rx_edge_detect #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = prev & ~level;
endmodule

// File: rtl/rx_word_framer.sv
module rx_word_framer #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_fall,
  input  logic              data_lvl,
  input  logic              sel_lvl,
  input  logic              sel_rise,
  input  logic              sel_fall,
  output logic              aligned,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              sel_edge;
  logic              take_bit;

  assign sel_edge  = sel_rise | sel_fall;
  assign take_bit  = aligned & sel_lvl & clk_fall & ~sel_edge;
  assign word_done = take_bit & (bit_cnt == LAST_BIT);
  assign word      = {shreg[WORD_W-2:0], data_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      if (sel_rise) aligned <= 1'b1;
      if (sel_edge) begin
        bit_cnt <= '0;
      end else if (take_bit) begin
        shreg   <= word;
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  // R3: alignment is sticky until reset
  a_r3_aligned_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);
  // R6: any select edge restarts the bit count
  a_r6_edge_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    sel_edge |=> (bit_cnt == '0));
  // R7: no bit is counted while select is low
  a_r7_low_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lvl && !sel_edge) |=> $stable(bit_cnt));
endmodule

// File: rtl/busy_sync_serial_rx.sv
module busy_sync_serial_rx #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_sel,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              synced
);
  import busy_sync_rx_pkg::*;

  logic [LINES-1:0]  raw_lines, s_lines, l_rise, l_fall;
  logic              word_done;
  logic [WORD_W-1:0] word;

  assign raw_lines[LINE_CLK]  = ser_clk;
  assign raw_lines[LINE_DATA] = ser_data;
  assign raw_lines[LINE_SEL]  = ser_sel;

  rx_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_lines), .sync_out(s_lines));

  rx_edge_detect #(.WIDTH(LINES), .RST_VAL(LINE_RST)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(s_lines), .rise(l_rise), .fall(l_fall));

  rx_word_framer #(.WORD_W(WORD_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .clk_fall(l_fall[LINE_CLK]), .data_lvl(s_lines[LINE_DATA]),
    .sel_lvl(s_lines[LINE_SEL]), .sel_rise(l_rise[LINE_SEL]),
    .sel_fall(l_fall[LINE_SEL]),
    .aligned(synced), .word_done(word_done), .word(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (word_done && !res_valid) begin
      res_valid <= 1'b1;
      res_data  <= word;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R2: nothing is presented before alignment
  a_r2_no_word_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !res_valid);
  // R5: a stalled result holds its value
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  // R5: a handshake retires the word
  a_r5_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);
endmodule

// File: tb/busy_sync_serial_rx_bench.sv
module busy_sync_serial_rx_bench;
  localparam int unsigned W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_sel = 1'b1, res_ready = 1'b0;
  logic res_valid, synced;
  logic [W-1:0] res_data;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busy_sync_serial_rx #(.WORD_W(W), .SYNC_STAGES(2)) u_busy_sync_serial_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_sel(ser_sel), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .synced(synced));

  localparam logic [W-1:0] VEC_IN  [6] = '{16'h8000, 16'h0001, 16'hA5C3, 16'hFFFF, 16'h0000, 16'h1234};
  localparam logic [W-1:0] VEC_EXP [6] = '{16'h8000, 16'h0001, 16'hA5C3, 16'hFFFF, 16'h0000, 16'h1234};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [W-1:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_data = w[W-1-i]; idle(4);
      ser_clk = 1'b1;      idle(4);
      ser_clk = 1'b0;      idle(4);
    end
  endtask

  task automatic conv_end();   // busy low then high
    ser_sel = 1'b0; idle(6);
    ser_sel = 1'b1; idle(6);
  endtask

  task automatic accept();
    res_ready = 1'b1; idle(1); res_ready = 1'b0;
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    chk("R1 valid after reset", 32'(res_valid), 0);
    chk("R1 synced after reset", 32'(synced), 0);
    send_bits(16'hBEEF, W); idle(4);
    chk("R2 no word before alignment", 32'(res_valid), 0);
    ser_sel = 1'b0; idle(6);
    chk("R3 falling select does not align", 32'(synced), 0);
    ser_sel = 1'b1; idle(6);
    chk("R3 rising select aligns", 32'(synced), 1);

    for (int v = 0; v < 6; v++) begin
      send_bits(VEC_IN[v], W); idle(2);
      chk("R4 word data", 32'(res_data), 32'(VEC_EXP[v]));
      chk("R5 valid after 16th edge", 32'(res_valid), 1);
      accept();
      chk("R5 valid cleared after handshake", 32'(res_valid), 0);
      conv_end();
    end

    // R5: exact boundary, 15 edges give nothing
    send_bits(16'h7001, W-1); idle(4);
    chk("R5 no word after 15 edges", 32'(res_valid), 0);
    // R6: select toggle mid-word discards partial bits
    conv_end();
    send_bits(16'hC3A5, W); idle(2);
    chk("R6 word after mid-word abort", 32'(res_data), 32'h0000C3A5);
    accept(); conv_end();

    // R7: clocking while select low is ignored
    ser_sel = 1'b0; idle(6);
    send_bits(16'hFFFF, W); idle(4);
    chk("R7 no word while select low", 32'(res_valid), 0);
    ser_sel = 1'b1; idle(6);
    send_bits(16'h0F0F, W); idle(2);
    chk("R7 clean word after low select", 32'(res_data), 32'h00000F0F);

    // R8: second word against stalled consumer is dropped; R5 hold
    conv_end();
    send_bits(16'h5555, W); idle(4);
    chk("R5 held while stalled", 32'(res_valid), 1);
    chk("R8 held word unchanged", 32'(res_data), 32'h00000F0F);
    accept();
    chk("R8 valid cleared", 32'(res_valid), 0);
    conv_end();
    send_bits(16'h9ABC, W); idle(2);
    chk("R8 framing intact after drop", 32'(res_data), 32'h00009ABC);
    accept();

    // R1/R3: reset clears alignment
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
    chk("R3 synced cleared by reset", 32'(synced), 0);
    chk("R1 valid cleared by reset", 32'(res_valid), 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule